// File: doc/BRIEF.md
# I/O Expander Register-Pair Transaction Sequencer

This block turns one host request into the full ordered list of bus-level commands needed to access one register pair of a 16-bit two-wire I/O expander. The host supplies a read/write flag, the expander's 3-bit strap address, a pointer byte that selects the register pair, and, for writes, two data bytes. The sequencer hands the commands one at a time to a separate byte engine. It waits for the engine's completion strobe before it issues the next command. When the transaction ends, it reports the two bytes read back, a one-cycle done strobe and an error flag.

A write has six steps: START, the address with the direction bit clear, the pointer byte, data for the first register, data for the second register, and STOP. A read has eight steps: START, the address with the direction bit clear, the pointer byte, a repeated START, the address with the direction bit set, a read that the master acknowledges, a read that the master answers with NACK, and STOP. If the slave refuses any byte the master sends, the sequencer skips straight to STOP and flags an error.

The FSM states are IDLE, START, ADDR_W, PTR, WDATA0, WDATA1, RESTART, ADDR_R, RDATA0, RDATA1, STOP and DONE. The transitions are:
- IDLE to START when a request is accepted.
- Each step state to its successor when the engine signals completion.
- PTR to WDATA0 for a write, or PTR to RESTART for a read.
- ADDR_W, PTR, WDATA0 or ADDR_R to STOP on a slave NACK (the abort transition).
- WDATA1 and RDATA1 to STOP.
- STOP to DONE.
- DONE to IDLE unconditionally.

Top module: `expander_pair_seq`

## Requirements
- R1: After reset, busy, done, err and eng_valid are all 0.
- R2: A request is accepted only while busy is 0. A req_valid seen while busy is 1, including the cycle in which done is high, has no effect on the command stream or the outputs.
- R3: Every address byte is {4'b0100, req_hw_addr[2:0], dir}, with dir = 0 on the first address and dir = 1 on the address after the repeated START.
- R4: A write issues, in order: START (op 0), WRITE address, WRITE pointer, WRITE req_wr0, WRITE req_wr1, STOP (op 2). WRITE is op 3.
- R5: A read issues, in order: START, WRITE address (dir 0), WRITE pointer, RESTART (op 1), WRITE address (dir 1), READ (op 4), READ, STOP.
- R6: eng_rd_nack is 0 on the first READ and 1 on the second READ.
- R7: If eng_done arrives with eng_nack = 1 for a WRITE command, the next command issued is STOP.
- R8: err rises on an abort and stays high until the next accepted request. The cycle after acceptance, err is 0.
- R9: When done is high and err is 0 after a read, rd_byte0 holds the first byte read and rd_byte1 holds the second.
- R10: done is high for exactly one cycle, after the STOP command completes. busy is high from the cycle after acceptance through the done cycle.
- R11: eng_valid is a one-cycle pulse. No new command is issued until eng_done answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_read | input | 1 | 1 = read register pair, 0 = write |
| req_hw_addr | input | 3 | Expander strap address |
| req_ptr | input | 8 | Register-pair pointer byte |
| req_wr0 | input | 8 | Data for first register of pair (write) |
| req_wr1 | input | 8 | Data for second register of pair (write) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Last transaction aborted on NACK |
| rd_byte0 | output | 8 | First byte read back |
| rd_byte1 | output | 8 | Second byte read back |
| eng_valid | output | 1 | Command strobe to byte engine |
| eng_op | output | 3 | Command: 0 START, 1 RESTART, 2 STOP, 3 WRITE, 4 READ |
| eng_wdata | output | 8 | Byte to send for WRITE |
| eng_rd_nack | output | 1 | For READ: 1 = answer with NACK |
| eng_done | input | 1 | Engine finished the current command |
| eng_nack | input | 1 | Slave refused the byte just written |
| eng_rdata | input | 8 | Byte received by a READ, valid with eng_done |

## Verification
Two events can land in the same cycle: a fresh host request and the closing done strobe. The request must lose, because the block is still busy in DONE. The bench provokes this by pulsing req_valid exactly in the done cycle. It then confirms that no START follows and that busy stays low. A NACK on the final write byte coincides with what would have been a normal STOP. The bench injects it there and judges that the command stream is unchanged while err still rises.

// File: rtl/expander_seq_pkg.sv
package expander_seq_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } eng_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR_W,
        ST_PTR,
        ST_WDATA0,
        ST_WDATA1,
        ST_RESTART,
        ST_ADDR_R,
        ST_RDATA0,
        ST_RDATA1,
        ST_STOP,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/expander_seq_fsm.sv
module expander_seq_fsm
    import expander_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_read,
    input  logic       lat_read,
    input  logic       eng_done,
    input  logic       eng_nack,
    output seq_state_e state,
    output logic       accept,
    output logic       issue,
    output logic       step_done,
    output logic       abort
);

    seq_state_e state_q, state_d;
    logic       issued_q;
    logic       is_step;
    logic       is_tx_step;

    // The request direction is latched by the datapath; req_read is unused here
    // except to keep the interface symmetric for accept-cycle decisions.
    logic       unused_rd;
    assign unused_rd = req_read;

    always_comb begin
        is_step    = 1'b0;
        is_tx_step = 1'b0;
        unique case (state_q)
            ST_START, ST_RESTART, ST_RDATA0, ST_RDATA1, ST_STOP: is_step = 1'b1;
            ST_ADDR_W, ST_PTR, ST_WDATA0, ST_WDATA1, ST_ADDR_R: begin
                is_step    = 1'b1;
                is_tx_step = 1'b1;
            end
            default: ;
        endcase
    end

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign issue     = is_step && !issued_q;
    assign step_done = is_step && issued_q && eng_done;
    assign abort     = step_done && is_tx_step && eng_nack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_START;
            ST_START:   if (step_done) state_d = ST_ADDR_W;
            ST_ADDR_W:  if (step_done) state_d = abort ? ST_STOP : ST_PTR;
            ST_PTR:     if (step_done) state_d = abort ? ST_STOP :
                                                 (lat_read ? ST_RESTART : ST_WDATA0);
            ST_WDATA0:  if (step_done) state_d = abort ? ST_STOP : ST_WDATA1;
            ST_WDATA1:  if (step_done) state_d = ST_STOP;
            ST_RESTART: if (step_done) state_d = ST_ADDR_R;
            ST_ADDR_R:  if (step_done) state_d = abort ? ST_STOP : ST_RDATA0;
            ST_RDATA0:  if (step_done) state_d = ST_RDATA1;
            ST_RDATA1:  if (step_done) state_d = ST_STOP;
            ST_STOP:    if (step_done) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            issued_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (step_done || state_d != state_q)
                issued_q <= 1'b0;
            else if (issue)
                issued_q <= 1'b1;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/expander_seq_datapath.sv
module expander_seq_datapath
    import expander_seq_pkg::*;
#(
    parameter int          HW_ADDR_W  = 3,
    parameter int          BYTE_W     = 8,
    parameter int          PREFIX_W   = 4,
    parameter logic [PREFIX_W-1:0] DEV_PREFIX = 4'b0100
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  seq_state_e           state,
    input  logic                 accept,
    input  logic                 step_done,
    input  logic                 abort,
    input  logic                 req_read,
    input  logic [HW_ADDR_W-1:0] req_hw_addr,
    input  logic [BYTE_W-1:0]    req_ptr,
    input  logic [BYTE_W-1:0]    req_wr0,
    input  logic [BYTE_W-1:0]    req_wr1,
    input  logic [BYTE_W-1:0]    eng_rdata,
    output logic                 lat_read,
    output eng_op_e              op,
    output logic [BYTE_W-1:0]    wdata,
    output logic                 rd_nack,
    output logic                 err,
    output logic [BYTE_W-1:0]    rd_byte0,
    output logic [BYTE_W-1:0]    rd_byte1
);

    localparam int ADDR_BYTE_W = PREFIX_W + HW_ADDR_W + 1;

    logic                 lat_read_q;
    logic [HW_ADDR_W-1:0] lat_addr_q;
    logic [BYTE_W-1:0]    lat_ptr_q, lat_wr0_q, lat_wr1_q;
    logic [BYTE_W-1:0]    rd0_q, rd1_q;
    logic                 err_q;
    logic [ADDR_BYTE_W-1:0] addr_wr, addr_rd;

    assign addr_wr = {DEV_PREFIX, lat_addr_q, 1'b0};
    assign addr_rd = {DEV_PREFIX, lat_addr_q, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_read_q <= 1'b0;
            lat_addr_q <= '0;
            lat_ptr_q  <= '0;
            lat_wr0_q  <= '0;
            lat_wr1_q  <= '0;
        end else if (accept) begin
            lat_read_q <= req_read;
            lat_addr_q <= req_hw_addr;
            lat_ptr_q  <= req_ptr;
            lat_wr0_q  <= req_wr0;
            lat_wr1_q  <= req_wr1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd0_q <= '0;
            rd1_q <= '0;
        end else if (step_done) begin
            if (state == ST_RDATA0) rd0_q <= eng_rdata;
            if (state == ST_RDATA1) rd1_q <= eng_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (accept)
            err_q <= 1'b0;
        else if (abort)
            err_q <= 1'b1;
    end

    always_comb begin
        op      = OP_START;
        wdata   = '0;
        rd_nack = 1'b0;
        unique case (state)
            ST_START:   op = OP_START;
            ST_ADDR_W:  begin op = OP_WRITE; wdata = BYTE_W'(addr_wr); end
            ST_PTR:     begin op = OP_WRITE; wdata = lat_ptr_q; end
            ST_WDATA0:  begin op = OP_WRITE; wdata = lat_wr0_q; end
            ST_WDATA1:  begin op = OP_WRITE; wdata = lat_wr1_q; end
            ST_RESTART: op = OP_RESTART;
            ST_ADDR_R:  begin op = OP_WRITE; wdata = BYTE_W'(addr_rd); end
            ST_RDATA0:  begin op = OP_READ; rd_nack = 1'b0; end
            ST_RDATA1:  begin op = OP_READ; rd_nack = 1'b1; end
            ST_STOP:    op = OP_STOP;
            default:    op = OP_START;
        endcase
    end

    assign lat_read = lat_read_q;
    assign err      = err_q;
    assign rd_byte0 = rd0_q;
    assign rd_byte1 = rd1_q;

endmodule

// File: rtl/expander_pair_seq.sv
module expander_pair_seq
    import expander_seq_pkg::*;
#(
    parameter int HW_ADDR_W = 3,
    parameter int BYTE_W    = 8,
    parameter int OP_W      = 3
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_read,
    input  logic [HW_ADDR_W-1:0] req_hw_addr,
    input  logic [BYTE_W-1:0]    req_ptr,
    input  logic [BYTE_W-1:0]    req_wr0,
    input  logic [BYTE_W-1:0]    req_wr1,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [BYTE_W-1:0]    rd_byte0,
    output logic [BYTE_W-1:0]    rd_byte1,
    output logic                 eng_valid,
    output logic [OP_W-1:0]      eng_op,
    output logic [BYTE_W-1:0]    eng_wdata,
    output logic                 eng_rd_nack,
    input  logic                 eng_done,
    input  logic                 eng_nack,
    input  logic [BYTE_W-1:0]    eng_rdata
);

    seq_state_e state;
    eng_op_e    op;
    logic       accept, issue, step_done, abort, lat_read;

    expander_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_read  (req_read),
        .lat_read  (lat_read),
        .eng_done  (eng_done),
        .eng_nack  (eng_nack),
        .state     (state),
        .accept    (accept),
        .issue     (issue),
        .step_done (step_done),
        .abort     (abort)
    );

    expander_seq_datapath #(
        .HW_ADDR_W (HW_ADDR_W),
        .BYTE_W    (BYTE_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .accept      (accept),
        .step_done   (step_done),
        .abort       (abort),
        .req_read    (req_read),
        .req_hw_addr (req_hw_addr),
        .req_ptr     (req_ptr),
        .req_wr0     (req_wr0),
        .req_wr1     (req_wr1),
        .eng_rdata   (eng_rdata),
        .lat_read    (lat_read),
        .op          (op),
        .wdata       (eng_wdata),
        .rd_nack     (eng_rd_nack),
        .err         (err),
        .rd_byte0    (rd_byte0),
        .rd_byte1    (rd_byte1)
    );

    assign eng_valid = issue;
    assign eng_op    = OP_W'(op);
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

endmodule

// File: rtl/expander_pair_seq_chk.sv
module expander_pair_seq_chk #(
    parameter int OP_W = 3
)(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic            eng_valid,
    input logic [OP_W-1:0] eng_op,
    input logic            eng_done,
    input logic            eng_nack
);

    logic nack_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            nack_seen <= 1'b0;
        else if (eng_valid)
            nack_seen <= 1'b0;
        else if (eng_done && eng_nack)
            nack_seen <= 1'b1;
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_valid);                                   // R1

    AST_ONE_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |=> !eng_valid);                               // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));                              // R10

    AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && nack_seen) |-> (eng_op == OP_W'(2)));      // R7

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> !err);                          // R8

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(req_valid && !busy)) |=> err);                 // R8

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);                          // R2

endmodule

bind expander_pair_seq expander_pair_seq_chk #(.OP_W(OP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .eng_valid (eng_valid),
    .eng_op    (eng_op),
    .eng_done  (eng_done),
    .eng_nack  (eng_nack)
);

// File: tb/expander_pair_seq_tb.sv
`timescale 1ns/1ps
module expander_pair_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_read = 1'b0;
    logic [2:0] req_hw_addr = '0;
    logic [7:0] req_ptr = '0, req_wr0 = '0, req_wr1 = '0;
    logic       busy, done, err, eng_valid, eng_rd_nack;
    logic [7:0] rd_byte0, rd_byte1, eng_wdata;
    logic [2:0] eng_op;
    logic       eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0] eng_rdata = '0;

    int checks = 0, failures = 0;
    bit finished = 0;

    // scoreboard of expected engine commands
    int exp_op[$];
    int exp_dat[$];
    int exp_ack[$];
    string cur_tag = "R4";

    // engine model configuration
    int nack_at = -1;
    int cmd_idx = 0;
    int rd_cnt = 0;
    int eng_cnt = 0;
    int last_op = 0;
    int last_idx = 0;
    logic [7:0] rv0 = '0, rv1 = '0;

    always #2.5 clk = ~clk;

    expander_pair_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_hw_addr(req_hw_addr), .req_ptr(req_ptr), .req_wr0(req_wr0), .req_wr1(req_wr1),
        .busy(busy), .done(done), .err(err), .rd_byte0(rd_byte0), .rd_byte1(rd_byte1),
        .eng_valid(eng_valid), .eng_op(eng_op), .eng_wdata(eng_wdata),
        .eng_rd_nack(eng_rd_nack), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_rdata(eng_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // engine model and scoreboard monitor
    always @(negedge clk) begin
        eng_done = 1'b0;
        eng_nack = 1'b0;
        if (eng_cnt > 0) begin
            if (eng_valid)
                check(1'b0, "R11 command while engine busy", 1, 0);
            eng_cnt--;
            if (eng_cnt == 0) begin
                eng_done = 1'b1;
                eng_nack = (last_op == 3) && (last_idx == nack_at);
                if (last_op == 4) begin
                    eng_rdata = (rd_cnt == 0) ? rv0 : rv1;
                    rd_cnt++;
                end
            end
        end else if (eng_valid) begin
            if (exp_op.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected command"}, int'(eng_op), -1);
            end else begin
                int eo, ed, ea;
                eo = exp_op.pop_front();
                ed = exp_dat.pop_front();
                ea = exp_ack.pop_front();
                check(int'(eng_op) == eo, {cur_tag, " command order"}, int'(eng_op), eo);
                if (eo == 3)
                    check(int'(eng_wdata) == ed, {cur_tag, " R3 written byte"}, int'(eng_wdata), ed);
                if (eo == 4)
                    check(int'(eng_rd_nack) == ea, "R6 read acknowledge", int'(eng_rd_nack), ea);
            end
            last_op  = int'(eng_op);
            last_idx = cmd_idx;
            cmd_idx++;
            eng_cnt  = 2;
        end
    end

    task automatic push(input int o, input int d, input int a);
        exp_op.push_back(o);
        exp_dat.push_back(d);
        exp_ack.push_back(a);
    endtask

    task automatic do_txn(input bit rd, input logic [2:0] a, input logic [7:0] p,
                          input logic [7:0] w0, input logic [7:0] w1, input int nk,
                          input logic [7:0] r0, input logic [7:0] r1,
                          input bit poke_busy, input bit poke_done);
        int ops[8];
        int dats[8];
        int acks[8];
        int n;
        int got;
        bit seen;
        n = rd ? 8 : 6;
        ops[0] = 0; dats[0] = 0; acks[0] = 0;
        ops[1] = 3; dats[1] = {4'b0100, a, 1'b0}; acks[1] = 0;
        ops[2] = 3; dats[2] = p; acks[2] = 0;
        if (rd) begin
            ops[3] = 1; dats[3] = 0; acks[3] = 0;
            ops[4] = 3; dats[4] = {4'b0100, a, 1'b1}; acks[4] = 0;
            ops[5] = 4; dats[5] = 0; acks[5] = 0;
            ops[6] = 4; dats[6] = 0; acks[6] = 1;
            ops[7] = 2; dats[7] = 0; acks[7] = 0;
        end else begin
            ops[3] = 3; dats[3] = w0; acks[3] = 0;
            ops[4] = 3; dats[4] = w1; acks[4] = 0;
            ops[5] = 2; dats[5] = 0; acks[5] = 0;
        end
        exp_op.delete(); exp_dat.delete(); exp_ack.delete();
        for (int i = 0; i < n; i++) begin
            if (nk >= 0 && i > nk) begin
                push(2, 0, 0);
                break;
            end
            push(ops[i], dats[i], acks[i]);
        end
        cur_tag = (nk >= 0) ? "R7" : (rd ? "R5" : "R4");
        nack_at = nk; cmd_idx = 0; rd_cnt = 0; rv0 = r0; rv1 = r1;

        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_hw_addr = a;
        req_ptr = p; req_wr0 = w0; req_wr1 = w1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        check(err == 1'b0, "R8 err cleared on accept", err, 0);
        if (poke_busy) begin
            // R2: request while busy must be ignored
            req_valid = 1'b1; req_read = ~rd; req_hw_addr = ~a;
            req_ptr = ~p; req_wr0 = ~w0; req_wr1 = ~w1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        seen = 0;
        for (int c = 0; c < 300; c++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        check(seen, "R10 done reached", seen, 1);
        check(busy == 1'b1, "R10 busy during done", busy, 1);
        check(err == (nk >= 0), "R8 err at done", err, (nk >= 0));
        if (rd && nk < 0) begin
            check(rd_byte0 == r0, "R9 first read byte", rd_byte0, r0);
            check(rd_byte1 == r1, "R9 second read byte", rd_byte1, r1);
        end
        got = exp_op.size();
        check(got == 0, {cur_tag, " commands left unissued"}, got, 0);
        if (poke_done) begin
            req_valid = 1'b1; req_read = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(done == 1'b0, "R10 done one cycle", done, 0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (poke_done) begin
                check(busy == 1'b0 && eng_valid == 1'b0, "R2 request in done cycle ignored",
                      {busy, eng_valid}, 0);
            end
        end
        check(err == (nk >= 0), "R8 err held after done", err, (nk >= 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy reset", busy, 0);
        check(done == 1'b0, "R1 done reset", done, 0);
        check(err == 1'b0, "R1 err reset", err, 0);
        check(eng_valid == 1'b0, "R1 eng_valid reset", eng_valid, 0);
        rst_n = 1'b1;
        // R4 write
        do_txn(0, 3'd5, 8'h06, 8'hA5, 8'h3C, -1, 8'h00, 8'h00, 0, 0);
        // R5 R6 R9 read
        do_txn(1, 3'd2, 8'h00, 8'h00, 8'h00, -1, 8'h81, 8'h7E, 0, 0);
        // R7 NACK on address
        do_txn(0, 3'd7, 8'h02, 8'h11, 8'h22, 1, 8'h00, 8'h00, 0, 0);
        // R8 clear on next request, R2 poke while busy
        do_txn(1, 3'd0, 8'h04, 8'h00, 8'h00, -1, 8'hF0, 8'h0F, 1, 0);
        // R7 NACK on final write byte, same-cycle request in done (R2)
        do_txn(0, 3'd1, 8'h08, 8'h55, 8'hAA, 4, 8'h00, 8'h00, 0, 1);
        // R7 NACK on read address after repeated START
        do_txn(1, 3'd6, 8'h0A, 8'h00, 8'h00, 4, 8'h12, 8'h34, 0, 0);
        // R7 NACK on pointer byte of a read
        do_txn(1, 3'd3, 8'h0C, 8'h00, 8'h00, 2, 8'h12, 8'h34, 0, 1);
        // R9 another read with fresh data after an abort
        do_txn(1, 3'd4, 8'h00, 8'h00, 8'h00, -1, 8'hC3, 8'h5A, 0, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule